// File: doc/BRIEF.md
# Flash Sector Protection Gate

This block keeps the write-protection state of a 1-Mbyte flash array split into sixteen uniform 64-Kbyte sectors, one protection bit per sector. A protection command sets or clears the bit of one sector, or sets or clears all sixteen bits together. A hardware lock input freezes every bit that is already set, while new protection can still be added.

Every program or erase request is judged against the protection state before the array controller acts on it. A request names its kind (page program, 4-Kbyte, 32-Kbyte or 64-Kbyte block erase, or whole-array erase), a start address and, for programs, a byte count. The gate answers one cycle later with grant or reject and the aligned start address. A reject raises a sticky failure flag that stays set until a later request is granted. The array, its timing and the serial front end are outside this block.

Top module: `sector_guard`

## Requirements
- R1: While reset is low and in the cycle after it is released, `prot_state` reads 16'hFFFF (every sector protected), `fail_flag` is 0 and `resp_valid` is 0.
- R2: A command with `pcmd_op` 0 sets bit `pcmd_sector` of `prot_state` and op 1 clears it. No other bit changes. The new value shows one cycle after the command.
- R3: Op 2 sets all sixteen bits and op 3 clears all sixteen bits, one cycle after the command. With `pcmd_valid` low, `prot_state` holds its value.
- R4: While `hw_lock` is 1, ops 1 and 3 leave every bit unchanged. Ops 0 and 2 still take effect.
- R5: Each cycle with `req_valid` high gives exactly one cycle later `resp_valid`=1 and exactly one of `resp_grant` or `resp_reject`. With no request, all three read 0.
- R6: A program (`req_kind` 0) is granted when `req_len` lies in 1..256 and the sector `req_addr[19:16]` is unprotected. Bytes past the page end wrap within the 256-byte page, so only the sector that holds the page is checked. `resp_addr` equals `req_addr`.
- R7: Erases of kind 1 (4 Kbytes), 2 (32 Kbytes) and 3 (64 Kbytes) return `resp_addr` with the low 12, 15 or 16 bits cleared.
- R8: An erase of kind 1, 2 or 3 is granted when the sector `req_addr[19:16]` is unprotected, and rejected otherwise. `req_len` is ignored.
- R9: A whole-array erase (kind 4) is granted only when all sixteen bits are clear. Its `resp_addr` is 0.
- R10: Kind codes 5, 6 and 7 are always rejected. `resp_addr` echoes `req_addr`.
- R11: A reject sets `fail_flag` in the same cycle as the response. A grant clears it. It does not change in a cycle without a response.
- R12: A request issued in the same cycle as a protection command is judged against the protection state from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_lock | input | 1 | Hardware lock of bits already set |
| pcmd_valid | input | 1 | Protection command strobe |
| pcmd_op | input | 2 | 0 set one, 1 clear one, 2 set all, 3 clear all |
| pcmd_sector | input | 4 | Sector index for ops 0 and 1 |
| req_valid | input | 1 | Access request strobe |
| req_kind | input | 3 | 0 program, 1/2/3 erase 4K/32K/64K, 4 whole array |
| req_addr | input | 20 | Byte start address |
| req_len | input | 9 | Program byte count |
| resp_valid | output | 1 | Response strobe |
| resp_grant | output | 1 | Request allowed |
| resp_reject | output | 1 | Request refused |
| resp_addr | output | 20 | Aligned start address |
| fail_flag | output | 1 | Sticky failure flag |
| prot_state | output | 16 | Protection bit per sector |

## Verification
The assertions assume that reset is held low for at least one clock edge before it is released. They also assume that `pcmd_op`, `pcmd_sector` and `req_kind` carry known values whenever their strobes are high. The bench holds reset for several edges. It changes inputs only at falling edges, drives every field with a defined value, and clears each strobe one cycle after it raises it. The sweep covers every sector-protection pattern with a single bit set and every pattern with a single bit clear. For each of them it tries all eight kind codes against all sixteen target sectors, plus the lock, byte-count and same-cycle cases.

// File: rtl/flash_guard_pkg.sv
// Package: shared encodings and geometry for the sector protection gate.
// Assumes a byte-addressed array whose sector index is the top address bits.
package flash_guard_pkg;

    // Protection command encoding (pcmd_op)
    typedef enum logic [1:0] {
        PROT_SET_ONE = 2'd0,
        PROT_CLR_ONE = 2'd1,
        PROT_SET_ALL = 2'd2,
        PROT_CLR_ALL = 2'd3
    } prot_op_e;

    // Access request encoding (req_kind); codes 5..7 are unused
    localparam logic [2:0] ACC_PROGRAM   = 3'd0;
    localparam logic [2:0] ACC_ERASE_4K  = 3'd1;
    localparam logic [2:0] ACC_ERASE_32K = 3'd2;
    localparam logic [2:0] ACC_ERASE_64K = 3'd3;
    localparam logic [2:0] ACC_ERASE_ALL = 3'd4;

    // Address bits covered by the smaller erase blocks
    localparam int unsigned BLK4K_BITS  = 12;
    localparam int unsigned BLK32K_BITS = 15;

endpackage

// File: rtl/prot_bank.sv
// Module: prot_bank
// Holds one protection bit per sector and applies single and global
// set/clear commands. While hw_lock is high, clear commands are dropped,
// so bits already set stay set; set commands always apply.
// Assumes cmd_idx < NUM_SECT when cmd_valid is high.
module prot_bank
    import flash_guard_pkg::*;
#(
    parameter int unsigned NUM_SECT = 16,
    localparam int unsigned IDX_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_lock,
    input  logic                cmd_valid,
    input  prot_op_e            cmd_op,
    input  logic [IDX_W-1:0]    cmd_idx,
    output logic [NUM_SECT-1:0] prot_bits
);

    for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
        logic sel;
        logic bit_q;
        logic bit_d;

        assign sel = (cmd_idx == IDX_W'(i));

        // Next value of this sector's bit for the current command
        always_comb begin
            bit_d = bit_q;
            if (cmd_valid) begin
                case (cmd_op)
                    PROT_SET_ONE: if (sel) bit_d = 1'b1;
                    PROT_CLR_ONE: if (sel && !hw_lock) bit_d = 1'b0;
                    PROT_SET_ALL: bit_d = 1'b1;
                    PROT_CLR_ALL: if (!hw_lock) bit_d = 1'b0;
                    default:      bit_d = bit_q;
                endcase
            end
        end

        // Bit register; every sector starts protected
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b1;
            else        bit_q <= bit_d;
        end

        assign prot_bits[i] = bit_q;
    end

endmodule

// File: rtl/req_decode.sv
// Module: req_decode
// Decodes an access request: aligns the start address to the erase
// block, extracts the target sector, flags a whole-array erase and
// checks that the kind code and program byte count are legal.
// Purely combinational.
module req_decode
    import flash_guard_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned SECT_BITS  = 16,
    parameter int unsigned PAGE_BYTES = 256,
    localparam int unsigned IDX_W     = ADDR_W - SECT_BITS,
    localparam int unsigned LEN_W     = $clog2(PAGE_BYTES) + 1
) (
    input  logic [2:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] start_addr,
    output logic [IDX_W-1:0]  sect_idx,
    output logic              whole_array,
    output logic              shape_ok
);

    localparam logic [ADDR_W-1:0] MASK_4K  = {ADDR_W{1'b1}} << BLK4K_BITS;
    localparam logic [ADDR_W-1:0] MASK_32K = {ADDR_W{1'b1}} << BLK32K_BITS;
    localparam logic [ADDR_W-1:0] MASK_SEC = {ADDR_W{1'b1}} << SECT_BITS;

    logic len_ok;

    // Program byte count must be 1..PAGE_BYTES
    assign len_ok = (len != '0) && (len <= LEN_W'(PAGE_BYTES));

    // Sector holding the start address (and, with page wrap, the whole page)
    assign sect_idx = addr[ADDR_W-1 -: IDX_W];

    // Alignment and legality per kind code
    always_comb begin
        start_addr  = addr;
        whole_array = 1'b0;
        shape_ok    = 1'b0;
        case (kind)
            ACC_PROGRAM: begin
                shape_ok = len_ok;
            end
            ACC_ERASE_4K: begin
                start_addr = addr & MASK_4K;
                shape_ok   = 1'b1;
            end
            ACC_ERASE_32K: begin
                start_addr = addr & MASK_32K;
                shape_ok   = 1'b1;
            end
            ACC_ERASE_64K: begin
                start_addr = addr & MASK_SEC;
                shape_ok   = 1'b1;
            end
            ACC_ERASE_ALL: begin
                start_addr  = '0;
                whole_array = 1'b1;
                shape_ok    = 1'b1;
            end
            default: begin
                start_addr = addr;
                shape_ok   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/req_judge.sv
// Module: req_judge
// Judges a decoded request against the protection bits and registers the
// response, one cycle after the request. Keeps the sticky failure flag:
// set by a reject, cleared by a grant.
// Assumes prot_bits is the state before any same-cycle command.
module req_judge #(
    parameter int unsigned NUM_SECT = 16,
    parameter int unsigned ADDR_W   = 20,
    localparam int unsigned IDX_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [IDX_W-1:0]    sect_idx,
    input  logic                whole_array,
    input  logic                shape_ok,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [NUM_SECT-1:0] prot_bits,
    output logic                resp_valid,
    output logic                resp_grant,
    output logic                resp_reject,
    output logic [ADDR_W-1:0]   resp_addr,
    output logic                fail_flag
);

    logic target_free;
    logic allow;

    // Whole array needs every bit clear; otherwise only the target sector
    assign target_free = whole_array ? (prot_bits == '0) : !prot_bits[sect_idx];
    assign allow       = shape_ok && target_free;

    // Response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_grant  <= 1'b0;
            resp_reject <= 1'b0;
            resp_addr   <= '0;
        end else begin
            resp_valid  <= req_valid;
            resp_grant  <= req_valid && allow;
            resp_reject <= req_valid && !allow;
            resp_addr   <= req_valid ? start_addr : '0;
        end
    end

    // Sticky failure flag
    always_ff @(posedge clk) begin
        if (!rst_n)         fail_flag <= 1'b0;
        else if (req_valid) fail_flag <= !allow;
    end

endmodule

// File: rtl/sector_guard.sv
// Module: sector_guard (top)
// Sector protection gate for a flash array: keeps the per-sector
// protection bits and grants or rejects program and erase requests.
// Assumes inputs are synchronous to clk; reset is synchronous, active low.
module sector_guard
    import flash_guard_pkg::*;
#(
    parameter int unsigned NUM_SECT   = 16,
    parameter int unsigned SECT_BITS  = 16,
    parameter int unsigned PAGE_BYTES = 256,
    localparam int unsigned IDX_W     = $clog2(NUM_SECT),
    localparam int unsigned ADDR_W    = IDX_W + SECT_BITS,
    localparam int unsigned LEN_W     = $clog2(PAGE_BYTES) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_lock,
    input  logic                pcmd_valid,
    input  logic [1:0]          pcmd_op,
    input  logic [IDX_W-1:0]    pcmd_sector,
    input  logic                req_valid,
    input  logic [2:0]          req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    output logic                resp_valid,
    output logic                resp_grant,
    output logic                resp_reject,
    output logic [ADDR_W-1:0]   resp_addr,
    output logic                fail_flag,
    output logic [NUM_SECT-1:0] prot_state
);

    logic [ADDR_W-1:0] dec_addr;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_all;
    logic              dec_ok;

    prot_bank #(
        .NUM_SECT (NUM_SECT)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_lock   (hw_lock),
        .cmd_valid (pcmd_valid),
        .cmd_op    (prot_op_e'(pcmd_op)),
        .cmd_idx   (pcmd_sector),
        .prot_bits (prot_state)
    );

    req_decode #(
        .ADDR_W     (ADDR_W),
        .SECT_BITS  (SECT_BITS),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_dec (
        .kind        (req_kind),
        .addr        (req_addr),
        .len         (req_len),
        .start_addr  (dec_addr),
        .sect_idx    (dec_idx),
        .whole_array (dec_all),
        .shape_ok    (dec_ok)
    );

    req_judge #(
        .NUM_SECT (NUM_SECT),
        .ADDR_W   (ADDR_W)
    ) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .sect_idx    (dec_idx),
        .whole_array (dec_all),
        .shape_ok    (dec_ok),
        .start_addr  (dec_addr),
        .prot_bits   (prot_state),
        .resp_valid  (resp_valid),
        .resp_grant  (resp_grant),
        .resp_reject (resp_reject),
        .resp_addr   (resp_addr),
        .fail_flag   (fail_flag)
    );

endmodule

// File: rtl/sector_guard_chk.sv
// Module: sector_guard_chk
// Temporal checks on the ports of sector_guard, attached by bind below.
module sector_guard_chk #(
    parameter int unsigned NUM_SECT = 16,
    parameter int unsigned ADDR_W   = 20,
    localparam int unsigned IDX_W   = $clog2(NUM_SECT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hw_lock,
    input logic                pcmd_valid,
    input logic [1:0]          pcmd_op,
    input logic [IDX_W-1:0]    pcmd_sector,
    input logic                req_valid,
    input logic [2:0]          req_kind,
    input logic                resp_valid,
    input logic                resp_grant,
    input logic                resp_reject,
    input logic                fail_flag,
    input logic [NUM_SECT-1:0] prot_state
);

    logic [NUM_SECT-1:0] sel_oh;
    assign sel_oh = NUM_SECT'(1) << pcmd_sector;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (prot_state == '1) && !fail_flag && !resp_valid);

    assert_single_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pcmd_valid && !pcmd_op[1]) |=>
        (((prot_state ^ $past(prot_state)) & ~$past(sel_oh)) == '0));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pcmd_valid |=> $stable(prot_state));

    assert_lock_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lock |=> ((prot_state & $past(prot_state)) == $past(prot_state)));

    assert_resp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid && (resp_grant != resp_reject));

    assert_no_stray_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid && !resp_grant && !resp_reject);

    assert_whole_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4 && prot_state != '0) |=> resp_reject);

    assert_bad_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind > 3'd4) |=> resp_reject);

    assert_flag_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (fail_flag == resp_reject));

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(fail_flag));

endmodule

bind sector_guard sector_guard_chk #(
    .NUM_SECT (NUM_SECT),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_lock     (hw_lock),
    .pcmd_valid  (pcmd_valid),
    .pcmd_op     (pcmd_op),
    .pcmd_sector (pcmd_sector),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .resp_valid  (resp_valid),
    .resp_grant  (resp_grant),
    .resp_reject (resp_reject),
    .fail_flag   (fail_flag),
    .prot_state  (prot_state)
);

// File: tb/sector_guard_tb.sv
`timescale 1ns/1ps
module sector_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_lock = 1'b0;
    logic        pcmd_valid = 1'b0;
    logic [1:0]  pcmd_op = 2'd0;
    logic [3:0]  pcmd_sector = 4'd0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [19:0] req_addr = 20'd0;
    logic [8:0]  req_len = 9'd0;
    logic        resp_valid, resp_grant, resp_reject, fail_flag;
    logic [19:0] resp_addr;
    logic [15:0] prot_state;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [15:0] m_prot;
    logic        m_fail;

    always #4 clk = ~clk;

    sector_guard u_dut (
        .clk(clk), .rst_n(rst_n), .hw_lock(hw_lock),
        .pcmd_valid(pcmd_valid), .pcmd_op(pcmd_op), .pcmd_sector(pcmd_sector),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_len(req_len), .resp_valid(resp_valid), .resp_grant(resp_grant),
        .resp_reject(resp_reject), .resp_addr(resp_addr),
        .fail_flag(fail_flag), .prot_state(prot_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Model of the protection bank (R2, R3, R4)
    function automatic logic [15:0] prot_next(input logic [15:0] cur, input logic [1:0] op,
                                              input logic [3:0] s, input logic lk);
        logic [15:0] n = cur;
        case (op)
            2'd0: n[s] = 1'b1;
            2'd1: if (!lk) n[s] = 1'b0;
            2'd2: n = 16'hFFFF;
            default: if (!lk) n = 16'h0000;
        endcase
        return n;
    endfunction

    task automatic do_pcmd(input logic [1:0] op, input logic [3:0] s, input string req);
        @(negedge clk);
        pcmd_valid = 1'b1; pcmd_op = op; pcmd_sector = s;
        @(negedge clk);
        pcmd_valid = 1'b0;
        m_prot = prot_next(m_prot, op, s, hw_lock);
        chk(req, {16'd0, prot_state}, {16'd0, m_prot});
    endtask

    // Request with expected grant and address computed from R6..R10
    task automatic do_req(input logic [2:0] k, input logic [19:0] a, input logic [8:0] n);
        logic        ok;
        logic [19:0] ea;
        string       tag;
        case (k)
            3'd0: begin ok = (n >= 1) && (n <= 256) && !m_prot[a[19:16]]; ea = a; tag = "R6"; end
            3'd1: begin ok = !m_prot[a[19:16]]; ea = {a[19:12], 12'd0}; tag = "R7/R8 4K"; end
            3'd2: begin ok = !m_prot[a[19:16]]; ea = {a[19:15], 15'd0}; tag = "R7/R8 32K"; end
            3'd3: begin ok = !m_prot[a[19:16]]; ea = {a[19:16], 16'd0}; tag = "R7/R8 64K"; end
            3'd4: begin ok = (m_prot == 16'h0); ea = 20'd0; tag = "R9"; end
            default: begin ok = 1'b0; ea = a; tag = "R10"; end
        endcase
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_len = n;
        @(negedge clk);
        req_valid = 1'b0;
        m_fail = !ok;
        chk({tag, " grant"}, {31'd0, resp_grant}, {31'd0, ok});
        chk("R5 one-hot", {30'd0, resp_valid, resp_reject}, {30'd0, 1'b1, !ok});
        chk({tag, " addr"}, {12'd0, resp_addr}, {12'd0, ea});
        chk("R11 flag", {31'd0, fail_flag}, {31'd0, m_fail});
        @(negedge clk);
        chk("R5 idle", {29'd0, resp_valid, resp_grant, resp_reject}, 32'd0);
        chk("R11 sticky", {31'd0, fail_flag}, {31'd0, m_fail});
    endtask

    task automatic sweep_targets();
        for (int t = 0; t < 16; t++) begin
            for (int k = 0; k < 8; k++) begin
                logic [15:0] lo = 16'((t * 16'h1357 + k * 16'h0F1 + 16'h0A5) & 16'hFFFF);
                do_req(3'(k), {4'(t), lo}, 9'(1 + ((t * 37 + k * 11) % 256)));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        m_prot = 16'hFFFF;
        m_fail = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 prot in reset", {16'd0, prot_state}, 32'h0000FFFF);
        chk("R1 flag in reset", {31'd0, fail_flag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 prot after reset", {16'd0, prot_state}, 32'h0000FFFF);
        chk("R1 resp after reset", {30'd0, resp_valid, fail_flag}, 32'd0);

        // R3 global ops
        do_pcmd(2'd3, 4'd0, "R3 clear all");
        do_pcmd(2'd2, 4'd0, "R3 set all");

        // R2 with R6..R10: one sector protected at a time
        for (int s = 0; s < 16; s++) begin
            do_pcmd(2'd3, 4'd0, "R3 clear all");
            do_pcmd(2'd0, 4'(s), "R2 set one");
            sweep_targets();
        end
        // R2 with R6..R10: one sector free at a time
        for (int s = 0; s < 16; s++) begin
            do_pcmd(2'd2, 4'd0, "R3 set all");
            do_pcmd(2'd1, 4'(s), "R2 clear one");
            sweep_targets();
        end
        // R9 all clear
        do_pcmd(2'd3, 4'd0, "R3 clear all");
        do_req(3'd4, 20'h3ABCD, 9'd5);

        // R6 byte counts at the edges, page wrap start address
        do_req(3'd0, 20'h2_00FF, 9'd0);
        do_req(3'd0, 20'h2_00FF, 9'd1);
        do_req(3'd0, 20'h2_00FF, 9'd256);
        do_req(3'd0, 20'h2_00FF, 9'd257);
        do_req(3'd0, 20'h2_FFFF, 9'd256);

        // R4 lock
        do_pcmd(2'd2, 4'd0, "R3 set all");
        hw_lock = 1'b1;
        for (int s = 0; s < 16; s++) do_pcmd(2'd1, 4'(s), "R4 clear one locked");
        do_pcmd(2'd3, 4'd0, "R4 clear all locked");
        hw_lock = 1'b0;
        do_pcmd(2'd3, 4'd0, "R3 clear all");
        hw_lock = 1'b1;
        do_pcmd(2'd0, 4'd5, "R4 set one locked");
        do_pcmd(2'd1, 4'd5, "R4 clear one locked");
        do_req(3'd3, 20'h5_1234, 9'd0);
        do_req(3'd3, 20'h6_1234, 9'd0);
        do_pcmd(2'd2, 4'd0, "R4 set all locked");
        hw_lock = 1'b0;

        // R12 same-cycle command and request
        do_pcmd(2'd3, 4'd0, "R3 clear all");
        @(negedge clk);
        pcmd_valid = 1'b1; pcmd_op = 2'd2; pcmd_sector = 4'd0;
        req_valid = 1'b1; req_kind = 3'd3; req_addr = 20'h3_4567; req_len = 9'd0;
        @(negedge clk);
        pcmd_valid = 1'b0; req_valid = 1'b0;
        chk("R12 grant on old state", {31'd0, resp_grant}, 32'd1);
        chk("R12 prot updated", {16'd0, prot_state}, 32'h0000FFFF);
        m_prot = 16'hFFFF;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule